// File: doc/BRIEF.md
# Distributed Interrupt Latency Timestamper

This block records the local time at both ends of a distributed-interrupt exchange between two network nodes, so that software can later work out the round-trip latency. It works in one of two roles. As the initiator it watches the incoming time-codes and sends a configured interrupt number when a time-code, seen through a mask, equals a trigger value. It records the time of that transmission, then waits for the reply and records the time at which the reply arrives. As the target it records the time at which a matching interrupt arrives and answers it straight away.

A mode bit selects how the exchange runs. In interrupt-only mode the target answers with an interrupt that carries its own transmit number. In interrupt-plus-acknowledge mode the target answers with an acknowledge that carries the number it received. A valid reception sets a status flag. The flag drives an interrupt line only while its enable is set, and it is cleared by writing 1. While the flag is set, both timestamps hold their values, so one measurement can be read out completely before the next one starts.

Top module: `dil_stamper`

## Requirements
- R1: After reset, out_req, sts_rcv and irq are 0, and ts_tx and ts_rx are 0.
- R2: While cfg_lat_en is 0, no transmission is sent and no reception is accepted.
- R3: In the initiator role (cfg_role=0), a time-code with tc_valid=1 and (tc_value & cfg_tc_mask) == (cfg_tc_trig & cfg_tc_mask) makes out_req=1 for exactly one cycle, starting the cycle after the time-code is sampled. That request has out_num=cfg_tx_num and out_is_ack=0. A time-code that does not match sends nothing.
- R4: ts_tx takes the value of local_time from the cycle in which the transmission is decided.
- R5: The initiator accepts a reception only while it waits for a reply and only if in_num equals cfg_rx_num and in_is_ack equals cfg_ack_mode. On acceptance it sets sts_rcv and loads local_time into ts_rx.
- R6: In the target role (cfg_role=1) with cfg_ack_mode=0, an incoming interrupt (in_is_ack=0) whose number equals cfg_rx_num loads ts_rx and sets sts_rcv. One cycle later the target sends an interrupt with out_num=cfg_tx_num and out_is_ack=0, and ts_tx records the same time as ts_rx.
- R7: In the target role with cfg_ack_mode=1, the reply is an acknowledge (out_is_ack=1) that carries the received interrupt number.
- R8: irq equals sts_rcv AND cfg_irq_en.
- R9: A pulse on sts_clr clears sts_rcv. While sts_rcv is 1, ts_tx and ts_rx do not change and no new transmission or reception is accepted.
- R10: Only one measurement is outstanding at a time. Matching time-codes that arrive before the reply is accepted are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_lat_en | input | 1 | Enables measurement activity |
| cfg_role | input | 1 | 0 = initiator, 1 = target |
| cfg_ack_mode | input | 1 | 0 = interrupt-only, 1 = interrupt plus acknowledge |
| cfg_tx_num | input | 5 | Number sent by this node |
| cfg_rx_num | input | 5 | Number this node expects to receive |
| cfg_tc_mask | input | TC_W | Mask applied in the time-code comparison |
| cfg_tc_trig | input | TC_W | Trigger time-code value |
| cfg_irq_en | input | 1 | Enables irq from the status flag |
| tc_valid | input | 1 | Time-code strobe |
| tc_value | input | TC_W | Time-code value |
| local_time | input | TIME_W | Current local time |
| in_valid | input | 1 | Incoming interrupt/acknowledge strobe |
| in_is_ack | input | 1 | Incoming event is an acknowledge |
| in_num | input | 5 | Incoming event number |
| sts_clr | input | 1 | Write-1 clear of the status flag |
| out_req | output | 1 | Outgoing event request, one cycle long |
| out_is_ack | output | 1 | Outgoing event is an acknowledge |
| out_num | output | 5 | Outgoing event number |
| ts_tx | output | TIME_W | Transmit timestamp |
| ts_rx | output | TIME_W | Receive timestamp |
| sts_rcv | output | 1 | Received-event status flag |
| irq | output | 1 | Interrupt output |

## Verification
Every decision is registered once, so out_req, out_num, out_is_ack, both timestamps and sts_rcv all take their new values at the first clock edge after the stimulus is sampled. irq follows sts_rcv in the same cycle, because it is formed combinationally. The bench drives each stimulus on a falling edge and holds it for exactly one rising edge. It then reads the results at the next falling edge, which is the single cycle in which a one-cycle out_req is visible. Checks for ignored events read the outputs at that same point, and they also confirm that the frozen timestamps still hold their earlier values.

// File: rtl/dil_pkg.sv
package dil_pkg;
  localparam int NUM_W = 5;

  typedef struct packed {
    logic             req;
    logic             ack;
    logic [NUM_W-1:0] num;
  } dil_evt_t;

  function automatic logic tc_hit(input logic [63:0] tc, input logic [63:0] trig,
                                  input logic [63:0] mask);
    return ((tc & mask) == (trig & mask));
  endfunction

  function automatic logic num_hit(input logic [NUM_W-1:0] got, input logic [NUM_W-1:0] want,
                                   input logic got_ack, input logic want_ack);
    return (got == want) && (got_ack == want_ack);
  endfunction
endpackage

// File: rtl/dil_trigger.sv
module dil_trigger #(
  parameter int TC_W = 6
) (
  input  logic            armed,
  input  logic            tc_valid,
  input  logic [TC_W-1:0] tc_value,
  input  logic [TC_W-1:0] tc_mask,
  input  logic [TC_W-1:0] tc_trig,
  output logic            fire
);
  import dil_pkg::*;
  always_comb begin
    fire = armed && tc_valid &&
           tc_hit(64'(tc_value), 64'(tc_trig), 64'(tc_mask));
  end
endmodule

// File: rtl/dil_rx_filter.sv
module dil_rx_filter (
  input  logic                      window,
  input  logic                      in_valid,
  input  logic                      in_is_ack,
  input  logic [dil_pkg::NUM_W-1:0] in_num,
  input  logic [dil_pkg::NUM_W-1:0] want_num,
  input  logic                      want_ack,
  output logic                      hit
);
  import dil_pkg::*;
  always_comb begin
    hit = window && in_valid && num_hit(in_num, want_num, in_is_ack, want_ack);
  end
endmodule

// File: rtl/dil_tx_stage.sv
module dil_tx_stage (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fire,
  input  logic                      reply,
  input  logic                      ack_mode,
  input  logic [dil_pkg::NUM_W-1:0] tx_num,
  input  logic [dil_pkg::NUM_W-1:0] echo_num,
  output dil_pkg::dil_evt_t         evt
);
  import dil_pkg::*;
  dil_evt_t nxt;

  always_comb begin
    nxt = '0;
    if (fire) begin
      nxt.req = 1'b1;
      nxt.num = tx_num;
    end else if (reply) begin
      nxt.req = 1'b1;
      nxt.ack = ack_mode;
      nxt.num = ack_mode ? echo_num : tx_num;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt <= '0;
    else        evt <= nxt;
  end
endmodule

// File: rtl/dil_stamper.sv
module dil_stamper #(
  parameter int TC_W   = 6,
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_lat_en,
  input  logic              cfg_role,
  input  logic              cfg_ack_mode,
  input  logic [4:0]        cfg_tx_num,
  input  logic [4:0]        cfg_rx_num,
  input  logic [TC_W-1:0]   cfg_tc_mask,
  input  logic [TC_W-1:0]   cfg_tc_trig,
  input  logic              cfg_irq_en,
  input  logic              tc_valid,
  input  logic [TC_W-1:0]   tc_value,
  input  logic [TIME_W-1:0] local_time,
  input  logic              in_valid,
  input  logic              in_is_ack,
  input  logic [4:0]        in_num,
  input  logic              sts_clr,
  output logic              out_req,
  output logic              out_is_ack,
  output logic [4:0]        out_num,
  output logic [TIME_W-1:0] ts_tx,
  output logic [TIME_W-1:0] ts_rx,
  output logic              sts_rcv,
  output logic              irq
);
  import dil_pkg::*;

  logic     busy;
  logic     fire;
  logic     rx_ok;
  logic     reply;
  logic     trig_armed;
  logic     rx_window;
  logic     want_ack;
  dil_evt_t evt;

  assign trig_armed = cfg_lat_en && !cfg_role && !busy && !sts_rcv;
  assign rx_window  = cfg_lat_en && !sts_rcv && (cfg_role || busy);
  assign want_ack   = cfg_ack_mode && !cfg_role;
  assign reply      = rx_ok && cfg_role;

  dil_trigger #(.TC_W(TC_W)) u_trig (
    .armed    (trig_armed),
    .tc_valid (tc_valid),
    .tc_value (tc_value),
    .tc_mask  (cfg_tc_mask),
    .tc_trig  (cfg_tc_trig),
    .fire     (fire)
  );

  dil_rx_filter u_rxf (
    .window    (rx_window),
    .in_valid  (in_valid),
    .in_is_ack (in_is_ack),
    .in_num    (in_num),
    .want_num  (cfg_rx_num),
    .want_ack  (want_ack),
    .hit       (rx_ok)
  );

  dil_tx_stage u_txs (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .reply    (reply),
    .ack_mode (cfg_ack_mode),
    .tx_num   (cfg_tx_num),
    .echo_num (in_num),
    .evt      (evt)
  );

  assign out_req    = evt.req;
  assign out_is_ack = evt.ack;
  assign out_num    = evt.num;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sts_rcv <= 1'b0;
      ts_tx   <= '0;
      ts_rx   <= '0;
    end else begin
      if (!cfg_lat_en || cfg_role) busy <= 1'b0;
      else if (fire)               busy <= 1'b1;
      else if (rx_ok)              busy <= 1'b0;

      if (rx_ok)        sts_rcv <= 1'b1;
      else if (sts_clr) sts_rcv <= 1'b0;

      if (fire || reply) ts_tx <= local_time;
      if (rx_ok)         ts_rx <= local_time;
    end
  end

  assign irq = sts_rcv && cfg_irq_en;
endmodule

// File: rtl/dil_stamper_chk.sv
module dil_stamper_chk #(
  parameter int TIME_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_lat_en,
  input logic              cfg_irq_en,
  input logic              fire,
  input logic              rx_ok,
  input logic              out_req,
  input logic [TIME_W-1:0] ts_tx,
  input logic [TIME_W-1:0] ts_rx,
  input logic              sts_rcv,
  input logic              irq
);
  // R3
  req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_req |=> !out_req);

  // R2
  no_tx_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_lat_en |=> !out_req);

  // R5
  rx_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ok |=> sts_rcv);

  // R9
  rx_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_rcv |=> $stable(ts_rx));

  // R9
  tx_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_rcv |=> $stable(ts_tx));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (sts_rcv && cfg_irq_en));

  // R9
  no_fire_while_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_rcv |-> !fire);
endmodule

bind dil_stamper dil_stamper_chk #(.TIME_W(TIME_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_lat_en (cfg_lat_en),
  .cfg_irq_en (cfg_irq_en),
  .fire       (fire),
  .rx_ok      (rx_ok),
  .out_req    (out_req),
  .ts_tx      (ts_tx),
  .ts_rx      (ts_rx),
  .sts_rcv    (sts_rcv),
  .irq        (irq)
);

// File: tb/dil_stamper_bench.sv
module dil_stamper_bench;
  localparam int TC_W   = 6;
  localparam int TIME_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_lat_en = 1'b0, cfg_role = 1'b0, cfg_ack_mode = 1'b0, cfg_irq_en = 1'b0;
  logic [4:0]        cfg_tx_num = '0, cfg_rx_num = '0;
  logic [TC_W-1:0]   cfg_tc_mask = '0, cfg_tc_trig = '0;
  logic              tc_valid = 1'b0;
  logic [TC_W-1:0]   tc_value = '0;
  logic [TIME_W-1:0] local_time = '0;
  logic              in_valid = 1'b0, in_is_ack = 1'b0;
  logic [4:0]        in_num = '0;
  logic              sts_clr = 1'b0;
  logic              out_req, out_is_ack, sts_rcv, irq;
  logic [4:0]        out_num;
  logic [TIME_W-1:0] ts_tx, ts_rx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dil_stamper #(.TC_W(TC_W), .TIME_W(TIME_W)) u_dil_stamper (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One time-code for one rising edge; returns at the following falling edge.
  task automatic send_tc(input logic [TC_W-1:0] v, input logic [TIME_W-1:0] t);
    tc_valid = 1'b1; tc_value = v; local_time = t;
    @(negedge clk);
    tc_valid = 1'b0;
  endtask

  task automatic send_in(input logic ack, input logic [4:0] n, input logic [TIME_W-1:0] t);
    in_valid = 1'b1; in_is_ack = ack; in_num = n; local_time = t;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic clear_sts();
    sts_clr = 1'b1;
    @(negedge clk);
    sts_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk(out_req == 0, "R1 out_req", out_req, 0);
    chk(sts_rcv == 0, "R1 sts_rcv", sts_rcv, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    chk(ts_tx == 0 && ts_rx == 0, "R1 timestamps", ts_tx | ts_rx, 0);
  endtask

  task automatic t_disabled();
    cfg_role = 0; cfg_tc_mask = 6'h0F; cfg_tc_trig = 6'h01;
    cfg_tx_num = 5'd4; cfg_rx_num = 5'd5;
    send_tc(6'h01, 32'd50);
    chk(out_req == 0, "R2 no send when disabled", out_req, 0);
    send_in(1'b0, 5'd5, 32'd51);
    chk(sts_rcv == 0, "R2 no receive when disabled", sts_rcv, 0);
  endtask

  task automatic t_trigger();
    cfg_lat_en = 1;
    send_tc(6'h02, 32'd90);
    chk(out_req == 0, "R3 mismatch sends nothing", out_req, 0);
    send_tc(6'h31, 32'd100);
    chk(out_req == 1, "R3 masked match sends", out_req, 1);
    chk(out_num == 5'd4, "R3 tx number", out_num, 4);
    chk(out_is_ack == 0, "R3 not ack", out_is_ack, 0);
    chk(ts_tx == 32'd100, "R4 tx timestamp", ts_tx, 100);
    @(negedge clk);
    chk(out_req == 0, "R3 one cycle only", out_req, 0);
  endtask

  task automatic t_single();
    send_tc(6'h11, 32'd200);
    chk(out_req == 0, "R10 second match ignored", out_req, 0);
    chk(ts_tx == 32'd100, "R10 ts_tx unchanged", ts_tx, 100);
  endtask

  task automatic t_rx_init();
    send_in(1'b0, 5'd6, 32'd250);
    chk(sts_rcv == 0, "R5 wrong number rejected", sts_rcv, 0);
    send_in(1'b1, 5'd5, 32'd260);
    chk(sts_rcv == 0, "R5 wrong type rejected", sts_rcv, 0);
    send_in(1'b0, 5'd5, 32'd300);
    chk(sts_rcv == 1, "R5 status set", sts_rcv, 1);
    chk(ts_rx == 32'd300, "R5 rx timestamp", ts_rx, 300);
    chk(irq == 0, "R8 irq masked", irq, 0);
    cfg_irq_en = 1;
    #1;
    chk(irq == 1, "R8 irq enabled", irq, 1);
  endtask

  task automatic t_freeze();
    @(negedge clk);
    send_tc(6'h01, 32'd500);
    chk(out_req == 0, "R9 no send while status set", out_req, 0);
    chk(ts_tx == 32'd100, "R9 ts_tx frozen", ts_tx, 100);
    send_in(1'b0, 5'd5, 32'd510);
    chk(ts_rx == 32'd300, "R9 ts_rx frozen", ts_rx, 300);
    clear_sts();
    chk(sts_rcv == 0, "R9 write-1 clear", sts_rcv, 0);
    chk(irq == 0, "R8 irq drops", irq, 0);
  endtask

  task automatic t_target_int();
    cfg_role = 1; cfg_ack_mode = 0; cfg_tx_num = 5'd7; cfg_rx_num = 5'd4;
    send_tc(6'h01, 32'd590);
    chk(out_req == 0, "R6 target ignores time-code", out_req, 0);
    send_in(1'b0, 5'd4, 32'd600);
    chk(out_req == 1, "R6 reply sent", out_req, 1);
    chk(out_num == 5'd7 && out_is_ack == 0, "R6 reply uses own tx number",
        {out_is_ack, out_num}, 7);
    chk(ts_rx == 32'd600 && ts_tx == 32'd600, "R6 both timestamps", ts_rx, 600);
    chk(sts_rcv == 1, "R6 status set", sts_rcv, 1);
    clear_sts();
  endtask

  task automatic t_target_ack();
    cfg_ack_mode = 1;
    send_in(1'b0, 5'd4, 32'd700);
    chk(out_req == 1 && out_is_ack == 1, "R7 ack reply", {out_req, out_is_ack}, 3);
    chk(out_num == 5'd4, "R7 ack echoes number", out_num, 4);
    clear_sts();
  endtask

  task automatic t_init_ack();
    cfg_role = 0; cfg_tx_num = 5'd3; cfg_rx_num = 5'd3;
    send_tc(6'h21, 32'd800);
    chk(out_req == 1 && out_num == 5'd3, "R3 send in ack mode", out_num, 3);
    send_in(1'b0, 5'd3, 32'd810);
    chk(sts_rcv == 0, "R5 interrupt rejected in ack mode", sts_rcv, 0);
    send_in(1'b1, 5'd3, 32'd820);
    chk(sts_rcv == 1 && ts_rx == 32'd820, "R5 ack accepted", ts_rx, 820);
    clear_sts();
  endtask

  initial begin
    #20000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_disabled();
    t_trigger();
    t_single();
    t_rx_init();
    t_freeze();
    t_target_int();
    t_target_ack();
    t_init_ack();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule